// File: doc/BRIEF.md
# Predicated Vector Compare Unit

This unit takes one integer comparison request and applies it across a vector of register-file elements. The result is a bit-per-element predicate mask. The request names two source registers and carries a flag per source that says whether that source is a vector. It also carries a vector length, a 3-bit compare code, an invert bit and the index of a destination predicate register. For element `i`, a vector source supplies register `base+i` and a scalar source supplies its own register every time. A scalar is therefore broadcast against the other operand. The request reuses a branch encoding, so the unit never touches a program counter. Its only result is the mask, written once to the predicate destination.

When neither source is a vector, the request is not vector work. The unit then gives a one-cycle scalar-branch indication and leaves the branch to the ordinary scalar path. Reserved compare codes raise an illegal-operation pulse instead.

The controller is a five-state machine:
- `ST_IDLE` waits for `start`.
- `ST_SWEEP` compares one element per clock.
- `ST_COMMIT` writes the mask and pulses `done`.
- `ST_PASS` reports a scalar branch.
- `ST_FAULT` reports a reserved code.

Its transitions are:
- IDLE to FAULT on a reserved code.
- IDLE to PASS when both sources are scalar.
- IDLE to COMMIT when the effective length is zero.
- IDLE to SWEEP otherwise.
- SWEEP to COMMIT after the last element.
- COMMIT, PASS and FAULT each return to IDLE.

Top module: `pvc_unit`

## Requirements
- R1: For element i, a vector source reads register (base+i) modulo NREG and a scalar source reads its base register; each element reads both sources in the same cycle.
- R2: Bit i of the mask is the compare result for element i. The codes are 000 equal, 001 not equal, 100 signed less-or-equal, 101 signed greater-or-equal, 110 unsigned less-than and 111 unsigned greater-or-equal. The first operand is the A source.
- R3: When `cmp_inv` is 1, every element bit below the effective length is the complement of the compare result.
- R4: The effective length is `vec_len`, clamped to XLEN. Mask bits at or above it are zero. A length of zero writes an all-zero mask.
- R5: If neither source is a vector and the code is not reserved, `scalar_br` pulses for one cycle on the clock after `start`. No mask is written.
- R6: Codes 010 and 011 pulse `illegal_op` on the clock after `start` and write no mask. This takes priority over R5.
- R7: One element is compared per clock. `done` and `pred_we` are high together for exactly one cycle, L+1 cycles after the `start` edge for effective length L. `pred_addr` equals the latched destination index.
- R8: The request fields are latched at `start`. A `start` or field change while `busy` is high has no effect on the running operation.
- R9: After reset, `busy`, `done`, `pred_we`, `scalar_br` and `illegal_op` are low. `busy` stays high from the cycle after an accepted `start` up to and including the cycle of its completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| src_a | input | $clog2(NREG) | Base register of the A source |
| src_b | input | $clog2(NREG) | Base register of the B source |
| a_vec | input | 1 | A source is a vector |
| b_vec | input | 1 | B source is a vector |
| vec_len | input | $clog2(XLEN+1) | Requested element count |
| cmp_code | input | 3 | Compare code |
| cmp_inv | input | 1 | Complement each element result |
| pred_dst | input | $clog2(NREG) | Predicate destination register |
| rf_a_addr | output | $clog2(NREG) | Register-file read address, A |
| rf_b_addr | output | $clog2(NREG) | Register-file read address, B |
| rf_a_data | input | XLEN | Read data for A, same cycle as address |
| rf_b_data | input | XLEN | Read data for B, same cycle as address |
| pred_we | output | 1 | Mask write strobe |
| pred_addr | output | $clog2(NREG) | Mask write register index |
| pred_data | output | XLEN | Mask value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Vector compare finished |
| scalar_br | output | 1 | Request handed on as a scalar branch |
| illegal_op | output | 1 | Reserved compare code seen |

## Verification
The bench sweeps every compare code, all four vector/scalar combinations and both invert settings. It uses lengths of zero, one, mid-range, exactly XLEN and above XLEN, with source bases that force the register index to wrap. A unit that broadcast a scalar wrongly, or failed to wrap, would put wrong bits in the mask. So would one that swapped signed and unsigned ordering or let invert leak above the length. A unit with an off-by-one in the sweep would miss the expected completion cycle or the top mask bit. Requests with both sources scalar, and requests with reserved codes, are checked for the right pulse and for never writing a mask. A second request injected mid-sweep must leave the running result unchanged.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'b000,
        CMP_NE  = 3'b001,
        CMP_RV0 = 3'b010,
        CMP_RV1 = 3'b011,
        CMP_SLE = 3'b100,
        CMP_SGE = 3'b101,
        CMP_ULT = 3'b110,
        CMP_UGE = 3'b111
    } cmp_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SWEEP,
        ST_COMMIT,
        ST_PASS,
        ST_FAULT
    } pvc_state_e;

    function automatic logic code_is_reserved(input logic [2:0] code);
        return code[2:1] == 2'b01;
    endfunction

endpackage

// File: rtl/pvc_cmp.sv
module pvc_cmp #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    input  logic [2:0]    code,
    input  logic          inv,
    output logic          hit
);
    import pvc_pkg::*;

    logic rel;

    always_comb begin
        case (code)
            CMP_EQ:  rel = (lhs == rhs);
            CMP_NE:  rel = (lhs != rhs);
            CMP_SLE: rel = ($signed(lhs) <= $signed(rhs));
            CMP_SGE: rel = ($signed(lhs) >= $signed(rhs));
            CMP_ULT: rel = (lhs < rhs);
            CMP_UGE: rel = (lhs >= rhs);
            default: rel = 1'b0;
        endcase
        hit = rel ^ inv;
    end

endmodule

// File: rtl/pvc_operand.sv
module pvc_operand #(
    parameter int AW  = 5,
    parameter int VLW = 7
) (
    input  logic [AW-1:0]  base,
    input  logic           is_vec,
    input  logic [VLW-1:0] elem,
    output logic [AW-1:0]  addr
);
    logic [AW+VLW-1:0] sum;

    always_comb begin
        sum  = {{VLW{1'b0}}, base} + {{AW{1'b0}}, elem};
        addr = is_vec ? sum[AW-1:0] : base;
    end

endmodule

// File: rtl/pvc_unit.sv
module pvc_unit #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int VLW = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   src_a,
    input  logic [AW-1:0]   src_b,
    input  logic            a_vec,
    input  logic            b_vec,
    input  logic [VLW-1:0]  vec_len,
    input  logic [2:0]      cmp_code,
    input  logic            cmp_inv,
    input  logic [AW-1:0]   pred_dst,
    output logic [AW-1:0]   rf_a_addr,
    output logic [AW-1:0]   rf_b_addr,
    input  logic [XLEN-1:0] rf_a_data,
    input  logic [XLEN-1:0] rf_b_data,
    output logic            pred_we,
    output logic [AW-1:0]   pred_addr,
    output logic [XLEN-1:0] pred_data,
    output logic            busy,
    output logic            done,
    output logic            scalar_br,
    output logic            illegal_op
);
    import pvc_pkg::*;

    localparam logic [VLW-1:0] VL_MAX = VLW'(XLEN);
    localparam logic [VLW-1:0] VL_ONE = VLW'(1);

    pvc_state_e state, state_nx;

    logic [AW-1:0]   base_a, base_b, dst_q;
    logic            va_q, vb_q, inv_q;
    logic [2:0]      code_q;
    logic [VLW-1:0]  len_q, elem_q, len_in;
    logic [XLEN-1:0] acc_q;
    logic            hit;
    logic            accept;

    assign accept = (state == ST_IDLE) && start;
    assign len_in = (vec_len > VL_MAX) ? VL_MAX : vec_len;

    pvc_operand #(.AW(AW), .VLW(VLW)) u_opa (
        .base(base_a), .is_vec(va_q), .elem(elem_q), .addr(rf_a_addr)
    );

    pvc_operand #(.AW(AW), .VLW(VLW)) u_opb (
        .base(base_b), .is_vec(vb_q), .elem(elem_q), .addr(rf_b_addr)
    );

    pvc_cmp #(.DW(XLEN)) u_cmp (
        .lhs(rf_a_data), .rhs(rf_b_data), .code(code_q), .inv(inv_q), .hit(hit)
    );

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (code_is_reserved(cmp_code))  state_nx = ST_FAULT;
                    else if (!a_vec && !b_vec)       state_nx = ST_PASS;
                    else if (len_in == '0)           state_nx = ST_COMMIT;
                    else                             state_nx = ST_SWEEP;
                end
            end
            ST_SWEEP:  state_nx = (elem_q == len_q - VL_ONE) ? ST_COMMIT : ST_SWEEP;
            ST_COMMIT: state_nx = ST_IDLE;
            ST_PASS:   state_nx = ST_IDLE;
            ST_FAULT:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request latch and mask accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_a <= '0;
            base_b <= '0;
            dst_q  <= '0;
            va_q   <= 1'b0;
            vb_q   <= 1'b0;
            inv_q  <= 1'b0;
            code_q <= 3'b000;
            len_q  <= '0;
            elem_q <= '0;
            acc_q  <= '0;
        end else if (accept) begin
            base_a <= src_a;
            base_b <= src_b;
            dst_q  <= pred_dst;
            va_q   <= a_vec;
            vb_q   <= b_vec;
            inv_q  <= cmp_inv;
            code_q <= cmp_code;
            len_q  <= len_in;
            elem_q <= '0;
            acc_q  <= '0;
        end else if (state == ST_SWEEP) begin
            acc_q  <= acc_q | (XLEN'(hit) << elem_q);
            elem_q <= elem_q + VL_ONE;
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_COMMIT);
        pred_we    = (state == ST_COMMIT);
        scalar_br  = (state == ST_PASS);
        illegal_op = (state == ST_FAULT);
        pred_addr  = dst_q;
        pred_data  = acc_q;
    end

endmodule

// File: rtl/pvc_unit_chk.sv
module pvc_unit_chk #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int VLW = $clog2(XLEN + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [AW-1:0]   src_a,
    input logic [AW-1:0]   src_b,
    input logic            a_vec,
    input logic            b_vec,
    input logic [VLW-1:0]  vec_len,
    input logic [2:0]      cmp_code,
    input logic [AW-1:0]   rf_a_addr,
    input logic [AW-1:0]   rf_b_addr,
    input logic            pred_we,
    input logic [XLEN-1:0] pred_data,
    input logic            busy,
    input logic            done,
    input logic            scalar_br,
    input logic            illegal_op
);
    logic [AW-1:0]   seen_a, seen_b;
    logic            seen_av, seen_bv;
    logic [VLW-1:0]  seen_len;
    logic [XLEN-1:0] low_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_a   <= '0;
            seen_b   <= '0;
            seen_av  <= 1'b1;
            seen_bv  <= 1'b1;
            seen_len <= '0;
        end else if (start && !busy) begin
            seen_a   <= src_a;
            seen_b   <= src_b;
            seen_av  <= a_vec;
            seen_bv  <= b_vec;
            seen_len <= vec_len;
        end
    end

    always_comb begin
        for (int j = 0; j < XLEN; j++) low_mask[j] = (j < int'(seen_len));
    end

    // R6
    reserved_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (cmp_code[2:1] == 2'b01) |=> illegal_op && !pred_we);

    // R5
    scalar_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (cmp_code[2:1] != 2'b01) && !a_vec && !b_vec |=> scalar_br && !pred_we);

    // R4
    mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_we |-> ((pred_data & ~low_mask) == '0));

    // R1
    scalar_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !seen_av |-> rf_a_addr == seen_a);

    // R1
    scalar_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !seen_bv |-> rf_b_addr == seen_b);

    // R9
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !scalar_br && !illegal_op |=> busy);

endmodule

bind pvc_unit pvc_unit_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
    .a_vec(a_vec), .b_vec(b_vec), .vec_len(vec_len), .cmp_code(cmp_code),
    .rf_a_addr(rf_a_addr), .rf_b_addr(rf_b_addr), .pred_we(pred_we),
    .pred_data(pred_data), .busy(busy), .done(done), .scalar_br(scalar_br),
    .illegal_op(illegal_op)
);

// File: tb/pvc_unit_test.sv
module pvc_unit_test;
    localparam int XL  = 8;
    localparam int NR  = 16;
    localparam int AW  = 4;
    localparam int VLW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_a = '0, src_b = '0, pred_dst = '0;
    logic          a_vec = 1'b0, b_vec = 1'b0, cmp_inv = 1'b0;
    logic [VLW-1:0] vec_len = '0;
    logic [2:0]    cmp_code = 3'b000;
    logic [AW-1:0] rf_a_addr, rf_b_addr, pred_addr;
    logic [XL-1:0] rf_a_data, rf_b_data, pred_data;
    logic          pred_we, busy, done, scalar_br, illegal_op;

    logic [XL-1:0] rf [NR];
    assign rf_a_data = rf[rf_a_addr];
    assign rf_b_data = rf[rf_b_addr];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pvc_unit #(.XLEN(XL), .NREG(NR)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
        .a_vec(a_vec), .b_vec(b_vec), .vec_len(vec_len), .cmp_code(cmp_code),
        .cmp_inv(cmp_inv), .pred_dst(pred_dst), .rf_a_addr(rf_a_addr),
        .rf_b_addr(rf_b_addr), .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
        .pred_we(pred_we), .pred_addr(pred_addr), .pred_data(pred_data),
        .busy(busy), .done(done), .scalar_br(scalar_br), .illegal_op(illegal_op)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit ref_rel(input logic [7:0] a, input logic [7:0] b, input int code);
        case (code)
            0: return a == b;
            1: return a != b;
            4: return $signed(a) <= $signed(b);
            5: return $signed(a) >= $signed(b);
            6: return a < b;
            7: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_op(input int sa, input int sb, input bit av, input bit bv,
                          input int vl, input int code, input bit inv, input int dst,
                          input bit poke);
        int vle, kind, exp_k, got_k;
        logic [XL-1:0] exp_mask;
        bit saw_we, busy_bad, ev_done, ev_sc, ev_il;
        logic [XL-1:0] got_mask;
        logic [AW-1:0] got_addr;
        vle = (vl > XL) ? XL : vl;
        kind = (code == 2 || code == 3) ? 2 : ((!av && !bv) ? 1 : 0);
        exp_k = (kind == 0) ? vle + 1 : 1;
        exp_mask = '0;
        for (int e = 0; e < vle; e++) begin
            logic [7:0] a, b;
            a = rf[(sa + (av ? e : 0)) % NR];
            b = rf[(sb + (bv ? e : 0)) % NR];
            exp_mask[e] = ref_rel(a, b, code) ^ inv;
        end
        @(negedge clk);
        src_a = AW'(sa); src_b = AW'(sb); a_vec = av; b_vec = bv;
        vec_len = VLW'(vl); cmp_code = 3'(code); cmp_inv = inv; pred_dst = AW'(dst);
        start = 1'b1;
        saw_we = 0; busy_bad = 0; got_k = 0;
        ev_done = 0; ev_sc = 0; ev_il = 0; got_mask = '0; got_addr = '0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke && k == 2) begin
                start = 1'b1; cmp_code = 3'b010; a_vec = ~av; src_a = AW'(sa + 3);
                vec_len = 4'd1; cmp_inv = ~inv; pred_dst = AW'(dst + 1);
            end
            if (poke && k == 3) start = 1'b0;
            if (!busy) busy_bad = 1;
            if (pred_we) begin
                saw_we = 1; got_mask = pred_data; got_addr = pred_addr;
            end
            if (done || scalar_br || illegal_op) begin
                got_k = k; ev_done = done; ev_sc = scalar_br; ev_il = illegal_op;
                break;
            end
        end
        start = 1'b0;
        chk(got_k == exp_k, "R7 completion cycle", got_k, exp_k);
        chk(!busy_bad, "R9 busy held until completion", busy_bad, 0);
        if (kind == 0) begin
            chk(ev_done && saw_we, "R7 done with mask write", {ev_done, saw_we}, 2'b11);
            chk(got_mask == exp_mask, poke ? "R8 mask unaffected by busy start" :
                "R1 R2 R3 R4 mask value", got_mask, exp_mask);
            chk(got_addr == AW'(dst), "R7 destination index", got_addr, dst);
        end else if (kind == 1) begin
            chk(ev_sc && !ev_done && !saw_we, "R5 scalar branch, no write",
                {ev_sc, ev_done, saw_we}, 3'b100);
        end else begin
            chk(ev_il && !ev_done && !saw_we && !ev_sc, "R6 illegal, no write",
                {ev_il, ev_done, saw_we}, 3'b100);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int vls [5] = '{0, 1, 5, 8, 12};
        for (int i = 0; i < NR; i++) rf[i] = 8'((i % 5) * 8'h47);
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({busy, done, pred_we, scalar_br, illegal_op} == 5'b0, "R9 reset outputs",
            {busy, done, pred_we, scalar_br, illegal_op}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, pred_we} == 3'b0, "R9 idle after reset", {busy, done, pred_we}, 0);
        for (int code = 0; code < 8; code++)
            for (int combo = 0; combo < 4; combo++)
                for (int inv = 0; inv < 2; inv++)
                    for (int v = 0; v < 5; v++)
                        run_op((code * 3 + combo * 5 + v) % NR, (code + 7 * v + inv) % NR,
                               combo[0], combo[1], vls[v], code, inv[0],
                               (code + combo + v) % NR, 1'b0);
        // R8: start pulses and field changes while busy
        run_op(13, 2, 1'b1, 1'b1, 8, 4, 1'b0, 5, 1'b1);
        run_op(6, 9, 1'b1, 1'b0, 6, 7, 1'b1, 11, 1'b1);
        run_op(0, 15, 1'b0, 1'b1, 12, 1, 1'b0, 3, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule